// File: doc/BRIEF.md
# Program Memory Address Decoder

This block sorts every 14-bit program-memory address into one of four targets: the internal RAM, the on-chip ROM, external memory, or a reserved hole that no memory answers. Two strap pins are captured while reset is held. The map strap chooses the layout: either the internal area sits at the bottom of the space or it sits at the top. The boot strap, combined with the map strap, sets the reset value of a ROM-enable bit.

The ROM-enable bit is bit 15 of a control word at data-memory address 0x3FFE. Software writes and reads it through a small data-memory port. When the bit is set, a window of ROM_WORDS addresses goes to the ROM. That window is anchored at the internal end of the current layout, and inside it the ROM wins over the RAM. When the bit is clear, the map is the plain RAM/reserved/external layout. The decoder registers its outputs: one select per memory, a reserved flag, and the address offset inside the chosen region.

Top module: `pmd_top`

## Requirements
- R1: While reset is high the ROM-enable bit is loaded with (map strap AND boot strap). A read of 0x3FFE after reset returns this value in bit 15.
- R2: With the map strap at 0, addresses 0 to RAM_WORDS-1 select the internal RAM (sel_ram_o) with offset equal to the address. This holds unless the ROM covers them.
- R3: With the map strap at 1, the last RAM_WORDS addresses select the internal RAM with offset = address − (16384 − RAM_WORDS). This holds unless the ROM covers them.
- R4: Addresses outside the 2048-word internal area go to external memory (sel_ext_o) with offset equal to the full address. This holds unless the ROM covers them. The internal area is 0x0000–0x07FF with the map strap at 0 and 0x3800–0x3FFF with it at 1.
- R5: When RAM_WORDS is 1024, the part of the internal area not taken by RAM raises rsvd_o and no select, with offset 0. This holds unless the ROM covers it.
- R6: With ROM enabled, the window selects the ROM (sel_rom_o) ahead of RAM, reserved and external. With the map strap at 0 the window is addresses below ROM_WORDS and the offset is the address. With it at 1 the window is addresses at or above 16384 − ROM_WORDS and the offset is address − (16384 − ROM_WORDS).
- R7: With ROM disabled, sel_rom_o never rises and the window follows the plain map of R2–R5.
- R8: A data-memory write with dm_we_i high to address 0x3FFE loads dm_wdata_i[15] into the ROM-enable bit on that clock edge. Writes to any other address leave it unchanged.
- R9: A read cycle (dm_we_i low) at 0x3FFE returns the ROM-enable bit in dm_rdata_o[15] one clock later, with the other bits zero. A read of any other address returns zero.
- R10: Strap changes after reset has been released have no effect on the layout or on the ROM-enable bit.
- R11: Outputs follow a request by one clock. With pm_req_i high, exactly one of sel_ram_o, sel_rom_o, sel_ext_o, rsvd_o is high. With pm_req_i low, all four and the offset are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_map_i | input | 1 | Layout strap: 0 = internal area low, 1 = internal area high |
| strap_boot_i | input | 1 | Boot strap, used only for the ROM-enable reset value |
| pm_req_i | input | 1 | Program-memory access request |
| pm_addr_i | input | 14 | Program-memory address |
| sel_ram_o | output | 1 | Internal RAM selected (registered) |
| sel_rom_o | output | 1 | On-chip ROM selected (registered) |
| sel_ext_o | output | 1 | External memory selected (registered) |
| rsvd_o | output | 1 | Access fell in a reserved hole (registered) |
| pm_offset_o | output | 14 | Offset within the selected region (registered) |
| dm_we_i | input | 1 | Data-memory write enable |
| dm_addr_i | input | 14 | Data-memory address |
| dm_wdata_i | input | 16 | Data-memory write data |
| dm_rdata_o | output | 16 | Control word read data, one clock after the read |

## Verification
The bench builds two copies side by side on shared stimulus. One has 1K RAM and 4K ROM. The other has 2K RAM and 8K ROM. The first copy brings the reserved holes of both layouts into reach. The second covers the full-RAM case, where no hole exists, and a ROM window that reaches far into external space. All four strap combinations are applied through resets, so both layouts and both ROM-enable reset values are exercised. Boundary addresses around every region edge are checked with the ROM on and with it off.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  typedef enum logic [1:0] {
    RGN_EXT  = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_ROM  = 2'd2,
    RGN_RSVD = 2'd3
  } region_e;
endpackage

// File: rtl/pmd_ctrl_reg.sv
module pmd_ctrl_reg #(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_map_i,
  input  logic              strap_boot_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit_i,
  output logic              map_hi_o,
  output logic              rom_en_o
);
  // straps are only looked at while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      map_hi_o <= strap_map_i;
      rom_en_o <= strap_map_i & strap_boot_i;
    end else if (wr_en_i && wr_addr_i == CTRL_ADDR) begin
      rom_en_o <= wr_bit_i;
    end
  end
endmodule

// File: rtl/pmd_map_decode.sv
module pmd_map_decode
  import pmd_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int RAM_WORDS = 1024,
  parameter int ROM_WORDS = 4096,
  parameter int INT_SPAN  = 2048
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_hi_i,
  input  logic              rom_en_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] offset_o
);
  localparam int SPACE = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] RAM_LO_END  = ADDR_W'(RAM_WORDS);
  localparam logic [ADDR_W-1:0] ROM_LO_END  = ADDR_W'(ROM_WORDS);
  localparam logic [ADDR_W-1:0] RAM_HI_BASE = ADDR_W'(SPACE - RAM_WORDS);
  localparam logic [ADDR_W-1:0] ROM_HI_BASE = ADDR_W'(SPACE - ROM_WORDS);

  logic in_rom, in_ram, in_hole;

  assign in_rom = rom_en_i && (map_hi_i ? (addr_i >= ROM_HI_BASE) : (addr_i < ROM_LO_END));
  assign in_ram = map_hi_i ? (addr_i >= RAM_HI_BASE) : (addr_i < RAM_LO_END);

  generate
    if (RAM_WORDS < INT_SPAN) begin : g_hole
      localparam logic [ADDR_W-1:0] INT_LO_END  = ADDR_W'(INT_SPAN);
      localparam logic [ADDR_W-1:0] INT_HI_BASE = ADDR_W'(SPACE - INT_SPAN);
      logic in_int;
      assign in_int  = map_hi_i ? (addr_i >= INT_HI_BASE) : (addr_i < INT_LO_END);
      assign in_hole = in_int && !in_ram;
    end else begin : g_full
      assign in_hole = 1'b0;
    end
  endgenerate

  always_comb begin
    if (in_rom) begin
      region_o = RGN_ROM;
      offset_o = map_hi_i ? addr_i - ROM_HI_BASE : addr_i;
    end else if (in_ram) begin
      region_o = RGN_RAM;
      offset_o = map_hi_i ? addr_i - RAM_HI_BASE : addr_i;
    end else if (in_hole) begin
      region_o = RGN_RSVD;
      offset_o = '0;
    end else begin
      region_o = RGN_EXT;
      offset_o = addr_i;
    end
  end
endmodule

// File: rtl/pmd_top.sv
module pmd_top
  import pmd_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 16,
  parameter int RAM_WORDS = 1024,
  parameter int ROM_WORDS = 4096,
  parameter int INT_SPAN  = 2048,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_map_i,
  input  logic              strap_boot_i,
  input  logic              pm_req_i,
  input  logic [ADDR_W-1:0] pm_addr_i,
  output logic              sel_ram_o,
  output logic              sel_rom_o,
  output logic              sel_ext_o,
  output logic              rsvd_o,
  output logic [ADDR_W-1:0] pm_offset_o,
  input  logic              dm_we_i,
  input  logic [ADDR_W-1:0] dm_addr_i,
  input  logic [DATA_W-1:0] dm_wdata_i,
  output logic [DATA_W-1:0] dm_rdata_o
);
  localparam int EN_BIT = DATA_W - 1;

  logic              map_hi_q;
  logic              rom_en_q;
  region_e           region;
  logic [ADDR_W-1:0] offset;
  logic              unused_wdata;

  assign unused_wdata = ^dm_wdata_i[EN_BIT-1:0];

  pmd_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .strap_map_i  (strap_map_i),
    .strap_boot_i (strap_boot_i),
    .wr_en_i      (dm_we_i),
    .wr_addr_i    (dm_addr_i),
    .wr_bit_i     (dm_wdata_i[EN_BIT]),
    .map_hi_o     (map_hi_q),
    .rom_en_o     (rom_en_q)
  );

  pmd_map_decode #(
    .ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS), .ROM_WORDS(ROM_WORDS), .INT_SPAN(INT_SPAN)
  ) u_dec (
    .addr_i   (pm_addr_i),
    .map_hi_i (map_hi_q),
    .rom_en_i (rom_en_q),
    .region_o (region),
    .offset_o (offset)
  );

  always_ff @(posedge clk) begin
    if (rst || !pm_req_i) begin
      sel_ram_o   <= 1'b0;
      sel_rom_o   <= 1'b0;
      sel_ext_o   <= 1'b0;
      rsvd_o      <= 1'b0;
      pm_offset_o <= '0;
    end else begin
      sel_ram_o   <= (region == RGN_RAM);
      sel_rom_o   <= (region == RGN_ROM);
      sel_ext_o   <= (region == RGN_EXT);
      rsvd_o      <= (region == RGN_RSVD);
      pm_offset_o <= offset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_rdata_o <= '0;
    end else if (!dm_we_i && dm_addr_i == CTRL_ADDR) begin
      dm_rdata_o <= DATA_W'(rom_en_q) << EN_BIT;
    end else begin
      dm_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FFE
) (
  input logic              clk,
  input logic              rst,
  input logic              pm_req_i,
  input logic              sel_ram_o,
  input logic              sel_rom_o,
  input logic              sel_ext_o,
  input logic              rsvd_o,
  input logic              dm_we_i,
  input logic [ADDR_W-1:0] dm_addr_i,
  input logic [DATA_W-1:0] dm_wdata_i,
  input logic [DATA_W-1:0] dm_rdata_o,
  input logic              map_hi_q,
  input logic              rom_en_q
);
  a_r11_one_target: assert property (@(posedge clk) disable iff (rst)
    pm_req_i |=> $onehot({sel_ram_o, sel_rom_o, sel_ext_o, rsvd_o}));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !pm_req_i |=> !(sel_ram_o || sel_rom_o || sel_ext_o || rsvd_o));

  a_r7_no_rom_when_off: assert property (@(posedge clk) disable iff (rst)
    !rom_en_q |=> !sel_rom_o);

  a_r8_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (dm_we_i && dm_addr_i == CTRL_ADDR) |=> rom_en_q == $past(dm_wdata_i[DATA_W-1]));

  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(dm_we_i && dm_addr_i == CTRL_ADDR) |=> $stable(rom_en_q));

  a_r9_read_back: assert property (@(posedge clk) disable iff (rst)
    (!dm_we_i && dm_addr_i == CTRL_ADDR) |=> dm_rdata_o == ({DATA_W{1'b0}} | ($past({{(DATA_W-1){1'b0}}, rom_en_q}) << (DATA_W-1))));

  a_r10_layout_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(map_hi_q));
endmodule

bind pmd_top pmd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pm_req_i   (pm_req_i),
  .sel_ram_o  (sel_ram_o),
  .sel_rom_o  (sel_rom_o),
  .sel_ext_o  (sel_ext_o),
  .rsvd_o     (rsvd_o),
  .dm_we_i    (dm_we_i),
  .dm_addr_i  (dm_addr_i),
  .dm_wdata_i (dm_wdata_i),
  .dm_rdata_o (dm_rdata_o),
  .map_hi_q   (map_hi_q),
  .rom_en_q   (rom_en_q)
);

// File: tb/tb_pmd_top.sv
module tb_pmd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_map = 1'b0, s_boot = 1'b0;
  logic        req = 1'b0;
  logic [13:0] paddr = '0;
  logic        we = 1'b0;
  logic [13:0] daddr = '0;
  logic [15:0] wdata = '0;

  logic        ram_a, rom_a, ext_a, rsv_a, ram_b, rom_b, ext_b, rsv_b;
  logic [13:0] off_a, off_b;
  logic [15:0] rd_a, rd_b;

  int errors = 0, checks = 0;
  logic rom_m = 1'b0;
  logic map_m = 1'b0;

  always #5 clk = ~clk;

  pmd_top #(.RAM_WORDS(1024), .ROM_WORDS(4096)) dut (
    .clk(clk), .rst(rst), .strap_map_i(s_map), .strap_boot_i(s_boot),
    .pm_req_i(req), .pm_addr_i(paddr),
    .sel_ram_o(ram_a), .sel_rom_o(rom_a), .sel_ext_o(ext_a), .rsvd_o(rsv_a),
    .pm_offset_o(off_a), .dm_we_i(we), .dm_addr_i(daddr), .dm_wdata_i(wdata),
    .dm_rdata_o(rd_a));

  pmd_top #(.RAM_WORDS(2048), .ROM_WORDS(8192)) dut_b (
    .clk(clk), .rst(rst), .strap_map_i(s_map), .strap_boot_i(s_boot),
    .pm_req_i(req), .pm_addr_i(paddr),
    .sel_ram_o(ram_b), .sel_rom_o(rom_b), .sel_ext_o(ext_b), .rsvd_o(rsv_b),
    .pm_offset_o(off_b), .dm_we_i(we), .dm_addr_i(daddr), .dm_wdata_i(wdata),
    .dm_rdata_o(rd_b));

  // expected {ram, rom, ext, rsvd, offset[13:0]}
  function automatic logic [17:0] expect_of(input int a, input logic mh, input logic ren,
                                            input int ram, input int rom);
    int rb, ob;
    if (mh) begin
      rb = 16384 - ram; ob = 16384 - rom;
      if (ren && a >= ob)  return {4'b0100, 14'(a - ob)};
      if (a >= rb)         return {4'b1000, 14'(a - rb)};
      if (a >= 14336)      return {4'b0001, 14'd0};
      return {4'b0010, 14'(a)};
    end else begin
      if (ren && a < rom)  return {4'b0100, 14'(a)};
      if (a < ram)         return {4'b1000, 14'(a)};
      if (a < 2048)        return {4'b0001, 14'd0};
      return {4'b0010, 14'(a)};
    end
  endfunction

  function automatic string tag_of(input logic [17:0] e, input logic mh);
    if (e[16]) return "R6";
    if (e[17]) return mh ? "R3" : "R2";
    if (e[14]) return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input int a, input string note);
    logic [17:0] ea, eb;
    @(negedge clk);
    req = 1'b1; paddr = 14'(a);
    @(negedge clk);
    ea = expect_of(a, map_m, rom_m, 1024, 4096);
    eb = expect_of(a, map_m, rom_m, 2048, 8192);
    check({tag_of(ea, map_m), note, " a"}, 32'({ram_a, rom_a, ext_a, rsv_a, off_a}), 32'(ea));
    check({tag_of(eb, map_m), note, " b"}, 32'({ram_b, rom_b, ext_b, rsv_b, off_b}), 32'(eb));
    req = 1'b0;
  endtask

  task automatic dm_write(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; daddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; daddr = '0; wdata = '0;
    if (a == 14'h3FFE) rom_m = d[15];
  endtask

  task automatic dm_read(input logic [13:0] a, input string tag);
    logic [15:0] e;
    @(negedge clk);
    we = 1'b0; daddr = a;
    @(negedge clk);
    e = (a == 14'h3FFE) ? {rom_m, 15'd0} : 16'd0;
    check({tag, " read a"}, 32'(rd_a), 32'(e));
    check({tag, " read b"}, 32'(rd_b), 32'(e));
    daddr = '0;
  endtask

  task automatic do_reset(input logic mh, input logic bt);
    @(negedge clk);
    rst = 1'b1; s_map = mh; s_boot = bt; req = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    map_m = mh; rom_m = mh & bt;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam int NCORN = 16;
  int corners [NCORN] = '{16'h0000, 16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h0FFF,
                          16'h1000, 16'h1FFF, 16'h2000, 16'h2FFF, 16'h37FF, 16'h3800,
                          16'h3BFF, 16'h3C00, 16'h3FFE, 16'h3FFF};

  initial begin
    void'($urandom(32'd1234));
    // reset state: all selects idle (R11)
    @(negedge clk);
    check("R11 reset outputs", 32'({ram_a, rom_a, ext_a, rsv_a, off_a}), 32'd0);
    for (int combo = 0; combo < 4; combo++) begin
      do_reset(combo[1], combo[0]);
      dm_read(14'h3FFE, "R1 reset enable");
      // directed corners with ROM off (R7) then on (R6)
      dm_write(14'h3FFE, 16'h0000);
      for (int i = 0; i < NCORN; i++) access(corners[i], " R7 off");
      dm_write(14'h3FFE, 16'h8000);
      dm_read(14'h3FFE, "R9 after set");
      for (int i = 0; i < NCORN; i++) access(corners[i], " R6 on");
      // other-address write ignored (R8), other-address read zero (R9)
      dm_write(14'h3FFD, 16'h0000);
      dm_read(14'h3FFE, "R8 other addr write");
      dm_read(14'h1234, "R9 other addr");
      dm_write(14'h3FFE, 16'h7FFF);
      dm_read(14'h3FFE, "R8 clear via bit15");
      // random mix
      for (int n = 0; n < 300; n++) begin
        if (($urandom % 16) == 0) dm_write(14'h3FFE, 16'($urandom));
        access(int'($urandom % 16384), " rand");
      end
      // idle request (R11)
      @(negedge clk);
      req = 1'b0; paddr = 14'h0001;
      @(negedge clk);
      check("R11 idle a", 32'({ram_a, rom_a, ext_a, rsv_a, off_a}), 32'd0);
      check("R11 idle b", 32'({ram_b, rom_b, ext_b, rsv_b, off_b}), 32'd0);
      // strap flips after reset ignored (R10)
      s_map = ~s_map; s_boot = ~s_boot;
      dm_read(14'h3FFE, "R10 enable kept");
      access(16'h0000, " R10 low");
      access(16'h3FFF, " R10 high");
      access(16'h3A00, " R10 mid");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule